// File: doc/BRIEF.md
# Interrupt Status and Vector Controller

This block keeps the event flags of a serial-bus controller and turns them into one level interrupt and two DMA request lines. The controller's datapath raises individual flags with single-cycle set pulses. Software reaches the block through a small register port with four addresses: an interrupt-enable register, a status register, a vector register and a DMA-configuration register.

Reading the vector register returns the number of the lowest flag that is both pending and enabled, counted from 1, and clears that flag in the same access. Software can therefore serve pending sources one read at a time. Turning on a DMA direction removes the matching ready flag from interrupt duty, so that flag drives the DMA request line instead.

Register addresses on `regAddr`: 0 is the enable register, 1 is status, 2 is the vector register and 3 is DMA configuration. Read data is combinational and valid in the same cycle as `regRdEn`. A write takes effect at the clock edge.

Top module: `irqVectorCtrl`

## Requirements
- R1: `irqOut` is registered. One clock edge after status or enable changes, it is 1 exactly when (status[4:0] AND enable) is non-zero.
- R2: A write to address 0 stores only bits 4:0. A read of address 0 returns them with bits 15:5 at zero. The enable bits are: bit 1 NACK, bit 2 access-ready, bit 3 receive-ready, bit 4 transmit-ready.
- R3: A read of address 2 returns the lowest set bit position of (status[4:0] AND enable) plus one, in bits 2:0. It returns 0 when no enabled flag is pending.
- R4: A vector read that returns a non-zero value clears only that status bit. A vector read that returns 0 changes nothing.
- R5: If a set pulse and a vector-read clear hit the same status bit in the same cycle, the bit stays set.
- R6: A write to address 3 stores only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). A read of address 3 returns them in those positions, with all other bits at zero.
- R7: `dmaRxReq` is registered and equals status bit 3 while receive DMA is enabled, and 0 otherwise. `dmaTxReq` behaves the same way with status bit 4 and transmit DMA enable.
- R8: A write to address 3 with bit 15 set clears enable bit 3. With bit 7 set, it clears enable bit 4. All other enable bits are unchanged.
- R9: A read of address 1 returns the stored status flags, with bit 12 replaced by the live `busBusy` input.
- R10: Writes to address 1 and address 2 change no register.
- R11: After reset, all registers and all three request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, valid in the same cycle as the read strobe |
| setPulse | input | 16 | Per-bit status set pulses from the datapath |
| busBusy | input | 1 | Live bus-busy indication |
| irqOut | output | 1 | Level interrupt request |
| dmaRxReq | output | 1 | Receive DMA request |
| dmaTxReq | output | 1 | Transmit DMA request |

## Verification
The bench targets the vector read when several flags are pending, some of them not enabled. A wrong priority order would report a higher source first, and a clear mask that is too wide would wipe flags that still need service. It also drives a set pulse into the bit being cleared in the same cycle. A design that lets the clear win would lose that event and leave `irqOut` low. Finally, it checks that turning on DMA clears only the matching enable bit, and that the busy bit on a status read follows the input rather than the stored flag. Getting either wrong would either keep a DMA-served flag interrupting or show stale busy state.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_DMA    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrEnable;
    logic    wrDma;
    logic    rdVector;
    regSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqvec_ctrl.sv
module irqvec_ctrl
  import irqvec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  output ctrlStrobe_t strb
);
  regSel_e sel;

  always_comb begin
    sel           = regSel_e'(regAddr);
    strb.rdSel    = sel;
    strb.wrEnable = regWrEn && (sel == SEL_ENABLE);
    strb.wrDma    = regWrEn && (sel == SEL_DMA);
    strb.rdVector = regRdEn && (sel == SEL_VECTOR);
  end

  // R10: status and vector addresses never produce a write strobe
  p_ro_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == 2'd1 || regAddr == 2'd2)) |-> !(strb.wrEnable || strb.wrDma));

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrEnable, strb.wrDma, strb.rdVector}));
endmodule

// File: rtl/irqvec_datapath.sv
module irqvec_datapath
  import irqvec_pkg::*;
#(
  parameter int STAT_W    = 16,
  parameter int IE_W      = 5,
  parameter int BUSY_POS  = 12,
  parameter int RX_POS    = 3,
  parameter int TX_POS    = 4,
  parameter int RXDMA_POS = 15,
  parameter int TXDMA_POS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [STAT_W-1:0] wrData,
  input  logic [STAT_W-1:0] setPulse,
  input  logic              busBusy,
  output logic [STAT_W-1:0] rdData,
  output logic              irqOut,
  output logic              dmaRxReq,
  output logic              dmaTxReq
);
  localparam int VEC_W = $clog2(IE_W + 1);

  logic [STAT_W-1:0] status, statusNext, clrMask;
  logic [IE_W-1:0]   enable, pending, clrLow;
  logic [VEC_W-1:0]  vecIdx;
  logic              dmaRxEn, dmaTxEn;

  assign pending = status[IE_W-1:0] & enable;

  // lowest pending enabled source wins
  always_comb begin
    vecIdx = '0;
    clrLow = '0;
    for (int i = IE_W - 1; i >= 0; i--) begin
      if (pending[i]) begin
        vecIdx    = VEC_W'(i + 1);
        clrLow    = '0;
        clrLow[i] = 1'b1;
      end
    end
  end

  always_comb begin
    clrMask = '0;
    if (strb.rdVector) clrMask[IE_W-1:0] = clrLow;
  end

  genvar g;
  generate
    for (g = 0; g < STAT_W; g++) begin : gStatBit
      assign statusNext[g] = setPulse[g] | (status[g] & ~clrMask[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status  <= '0;
      enable  <= '0;
      dmaRxEn <= 1'b0;
      dmaTxEn <= 1'b0;
    end else begin
      status <= statusNext;
      if (strb.wrEnable) begin
        enable <= wrData[IE_W-1:0];
      end else if (strb.wrDma) begin
        if (wrData[RXDMA_POS]) enable[RX_POS] <= 1'b0;
        if (wrData[TXDMA_POS]) enable[TX_POS] <= 1'b0;
      end
      if (strb.wrDma) begin
        dmaRxEn <= wrData[RXDMA_POS];
        dmaTxEn <= wrData[TXDMA_POS];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut   <= 1'b0;
      dmaRxReq <= 1'b0;
      dmaTxReq <= 1'b0;
    end else begin
      irqOut   <= |pending;
      dmaRxReq <= dmaRxEn & status[RX_POS];
      dmaTxReq <= dmaTxEn & status[TX_POS];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      SEL_ENABLE: rdData[IE_W-1:0] = enable;
      SEL_STATUS: begin
        rdData           = status;
        rdData[BUSY_POS] = busBusy;
      end
      SEL_VECTOR: rdData[VEC_W-1:0] = vecIdx;
      SEL_DMA: begin
        rdData[RXDMA_POS] = dmaRxEn;
        rdData[TXDMA_POS] = dmaTxEn;
      end
    endcase
  end

  p_irq_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    (|(status[IE_W-1:0] & enable)) |=> irqOut);
  p_irq_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(|(status[IE_W-1:0] & enable)) |=> !irqOut);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|(clrMask & ~setPulse)) |=> ((status & $past(clrMask & ~setPulse)) == '0));
  p_clear_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clrMask));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|setPulse) |=> ((status & $past(setPulse)) == $past(setPulse)));

  p_rx_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    dmaRxReq |-> $past(dmaRxEn && status[RX_POS]));
  p_tx_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    dmaTxReq |-> $past(dmaTxEn && status[TX_POS]));

  p_dma_rx_ie_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDma && wrData[RXDMA_POS]) |=> !enable[RX_POS]);
  p_dma_tx_ie_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDma && wrData[TXDMA_POS]) |=> !enable[TX_POS]);
endmodule

// File: rtl/irqVectorCtrl.sv
module irqVectorCtrl
  import irqvec_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter int IE_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [STAT_W-1:0] regWrData,
  output logic [STAT_W-1:0] regRdData,
  input  logic [STAT_W-1:0] setPulse,
  input  logic              busBusy,
  output logic              irqOut,
  output logic              dmaRxReq,
  output logic              dmaTxReq
);
  ctrlStrobe_t strb;

  irqvec_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irqvec_datapath #(
    .STAT_W (STAT_W),
    .IE_W   (IE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .setPulse (setPulse),
    .busBusy  (busBusy),
    .rdData   (regRdData),
    .irqOut   (irqOut),
    .dmaRxReq (dmaRxReq),
    .dmaTxReq (dmaTxReq)
  );
endmodule

// File: tb/sim_irqVectorCtrl.sv
module sim_irqVectorCtrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = '0, regRdData, setPulse = '0;
  logic        busBusy = 1'b0;
  logic        irqOut, dmaRxReq, dmaTxReq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  irqVectorCtrl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .setPulse(setPulse), .busBusy(busBusy), .irqOut(irqOut),
    .dmaRxReq(dmaRxReq), .dmaTxReq(dmaTxReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; tick(); rstN = 1'b1; @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    tick();
    regRdEn = 1'b0;
  endtask

  task automatic pulse(logic [15:0] m);
    setPulse = m; tick(); setPulse = '0;
  endtask

  task automatic testReset();
    logic [15:0] d;
    doReset();
    check("R11 irq", {15'd0, irqOut}, 16'd0);
    check("R11 dma", {14'd0, dmaRxReq, dmaTxReq}, 16'd0);
    rd(2'd0, d); check("R11 enable", d, 16'h0000);
    rd(2'd1, d); check("R11 status", d, 16'h0000);
    rd(2'd3, d); check("R11 dmacfg", d, 16'h0000);
    rd(2'd2, d); check("R11 vector", d, 16'h0000);
  endtask

  task automatic testEnableWidth();
    logic [15:0] d;
    doReset();
    wr(2'd0, 16'hFFFF); rd(2'd0, d); check("R2 enable mask", d, 16'h001F);
  endtask

  task automatic testIrqLevel();
    doReset();
    wr(2'd0, 16'h0002);
    pulse(16'h0020);
    tick(); check("R1 non-enabled flag", {15'd0, irqOut}, 16'd0);
    pulse(16'h0002);
    check("R1 registered delay", {15'd0, irqOut}, 16'd0);
    tick(); check("R1 irq raised", {15'd0, irqOut}, 16'd1);
  endtask

  task automatic testVector();
    logic [15:0] d;
    doReset();
    wr(2'd0, 16'h001E);
    pulse(16'h0015);
    rd(2'd2, d); check("R3 lowest enabled", d, 16'd3);
    rd(2'd1, d); check("R4 only bit2 cleared", d, 16'h0011);
    rd(2'd2, d); check("R3 next source", d, 16'd5);
    rd(2'd1, d); check("R4 bit4 cleared", d, 16'h0001);
    rd(2'd2, d); check("R3 none pending", d, 16'd0);
    rd(2'd1, d); check("R4 empty read no change", d, 16'h0001);
    check("R1 irq dropped", {15'd0, irqOut}, 16'd0);
  endtask

  task automatic testSetWins();
    logic [15:0] d;
    doReset();
    wr(2'd0, 16'h0004);
    pulse(16'h0004);
    regRdEn = 1'b1; regAddr = 2'd2; setPulse = 16'h0004;
    #1 d = regRdData;
    tick();
    regRdEn = 1'b0; setPulse = '0;
    check("R5 vector value", d, 16'd3);
    rd(2'd1, d); check("R5 set survives clear", d, 16'h0004);
    tick(); check("R5 irq stays", {15'd0, irqOut}, 16'd1);
  endtask

  task automatic testDmaCfg();
    logic [15:0] d;
    doReset();
    wr(2'd3, 16'hFFFF); rd(2'd3, d); check("R6 dma mask", d, 16'h8080);
    doReset();
    wr(2'd0, 16'h001F);
    wr(2'd3, 16'h8000); rd(2'd0, d); check("R8 rx clears ie3", d, 16'h0017);
    wr(2'd3, 16'h0080); rd(2'd0, d); check("R8 tx clears ie4", d, 16'h0007);
    rd(2'd3, d); check("R6 tx only", d, 16'h0080);
  endtask

  task automatic testDmaReq();
    doReset();
    wr(2'd3, 16'h8080);
    pulse(16'h0008); tick();
    check("R7 rx req", {14'd0, dmaRxReq, dmaTxReq}, 16'h0002);
    pulse(16'h0010); tick();
    check("R7 both req", {14'd0, dmaRxReq, dmaTxReq}, 16'h0003);
    doReset();
    pulse(16'h0018); tick();
    check("R7 gated off", {14'd0, dmaRxReq, dmaTxReq}, 16'h0000);
    wr(2'd3, 16'h0080); tick();
    check("R7 tx only", {14'd0, dmaRxReq, dmaTxReq}, 16'h0001);
  endtask

  task automatic testBusyAndRo();
    logic [15:0] d;
    doReset();
    busBusy = 1'b1; rd(2'd1, d); check("R9 live busy", d, 16'h1000);
    pulse(16'h1000); busBusy = 1'b0;
    rd(2'd1, d); check("R9 stored bit12 hidden", d, 16'h0000);
    wr(2'd1, 16'hFFFF); wr(2'd2, 16'hFFFF);
    rd(2'd1, d); check("R10 status unchanged", d, 16'h0000);
    rd(2'd0, d); check("R10 enable unchanged", d, 16'h0000);
    rd(2'd3, d); check("R10 dma unchanged", d, 16'h0000);
    tick(); check("R10 irq low", {15'd0, irqOut}, 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testEnableWidth();
    testIrqLevel();
    testVector();
    testSetWins();
    testDmaCfg();
    testDmaReq();
    testBusyAndRo();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule